// File: doc/BRIEF.md
# Phase-Encoded Record Writer

This block turns a stream of 9-bit characters into phase-encoded write levels for a nine-track tape. There is one level per track and one level change opportunity per half bit cell. A single pulse on `start` opens a record. The writer then frames the record by itself: a run of all-zero characters and one all-ones character go out before the data, and the same framing in reverse order closes it. Data characters are taken over a valid/ready handshake. The character flagged `last` ends the data part. After the final half cell of the closing framing has been driven, `done` pulses for one cycle.

Each track carries one bit of every character, and track i carries bit i. Within a bit cell, the first half drives the complement of the bit and the second half drives the bit itself. A one therefore rises at mid-cell and a zero falls at mid-cell. When two neighbouring cells carry the same bit, an extra edge appears on their shared boundary. Timing comes only from a one-cycle half-cell strobe `half_tick`, so the block works at any tape speed the surrounding logic sets.

Top module: `pe_record_writer`

## Requirements
- R1: After a record starts, the first 80 consumed half-cell strobes drive 40 all-zero cells on every track, and the next two drive one all-ones cell. Only then is any data cell written.
- R2: Every cell takes exactly two consumed strobes. The first drives the complement of the cell's bit, the second drives the bit. Track levels change only at a clock edge where `half_tick` is high.
- R3: When two consecutive cells on a track carry equal bits, the level reverses at the boundary between them. When they differ, no boundary edge appears.
- R4: Accepted characters are written one per cell, in acceptance order. Bit i of `s_data` goes to `trk_out[i]`, with the parity bit at index 8.
- R5: After the cell of the character marked last, one all-ones cell and then 40 all-zero cells are written. `done` is high for exactly the one cycle in which the final half-cell level first appears.
- R6: `s_ready` is low while idle and throughout the opening framing. `s_valid` has no effect on the output during those times.
- R7: Once a character with `s_last` set has been accepted, `s_ready` stays low until the next record starts, and further offered characters are not written.
- R8: If no accepted character is waiting when a data cell should begin, that strobe is skipped. All track levels hold, and the cell begins at the next strobe after a character is available.
- R9: `start` has no effect while a record is in progress. `half_tick` has no effect while idle.
- R10: A synchronous reset drives all track levels low, deasserts `s_ready` and `done`, and returns the writer to idle, even in the middle of a record. A later `start` then writes a complete fresh record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| half_tick | input | 1 | One-cycle strobe marking each half bit cell |
| start | input | 1 | Opens a record when the writer is idle |
| s_valid | input | 1 | Character offered |
| s_data | input | 9 | Character: eight data bits plus parity at bit 8 |
| s_last | input | 1 | Marks the final data character of the record |
| s_ready | output | 1 | Character accepted at this edge if `s_valid` is high |
| trk_out | output | 9 | Write level per track |
| done | output | 1 | One-cycle pulse when the record is fully written |

## Verification
The assertions take for granted that `half_tick` is a single-cycle pulse with at least one idle cycle between pulses. They also assume that `s_data` and `s_last` hold steady while `s_valid` waits for `s_ready`. Without those conditions, the input register could not refill between cells, and the per-track flip check would have no settled first half to compare against. The stimulus pulses `half_tick` once every four cycles and changes inputs only at falling edges. Characters are offered early (during the opening framing), late (to force skipped strobes), after the last character, and with a stray `start` in the middle of the data.

// File: rtl/pe_wr_pkg.sv
package pe_wr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_DATA = 2'd2,
        ST_POST = 2'd3
    } wr_state_e;

    typedef enum logic [1:0] {
        SRC_ZERO = 2'd0,
        SRC_ONES = 2'd1,
        SRC_DATA = 2'd2
    } cell_src_e;

endpackage

// File: rtl/pe_wr_inbuf.sv
module pe_wr_inbuf #(
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept_en,
    input  logic             clear,
    input  logic             take,
    input  logic             s_valid,
    input  logic [WIDTH-1:0] s_data,
    input  logic             s_last,
    output logic             s_ready,
    output logic             buf_vld,
    output logic [WIDTH-1:0] buf_data,
    output logic             buf_last
);

    typedef struct packed {
        logic             vld;
        logic [WIDTH-1:0] data;
        logic             last;
        logic             lock;
    } ib_t;

    ib_t ib_q, ib_d;

    always_comb begin
        ib_d    = ib_q;
        s_ready = accept_en && !ib_q.vld && !ib_q.lock;
        if (take) begin
            ib_d.vld = 1'b0;
        end
        if (s_valid && s_ready) begin
            ib_d.vld  = 1'b1;
            ib_d.data = s_data;
            ib_d.last = s_last;
            ib_d.lock = s_last;
        end
        if (clear) begin
            ib_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ib_q <= '0;
        end else begin
            ib_q <= ib_d;
        end
    end

    assign buf_vld  = ib_q.vld;
    assign buf_data = ib_q.data;
    assign buf_last = ib_q.last;

    AST_NO_READY_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        (s_valid && s_ready && s_last) |=> !s_ready); // R7

endmodule

// File: rtl/pe_wr_framer.sv
module pe_wr_framer
    import pe_wr_pkg::*;
#(
    parameter int PRE_ZEROS  = 40,
    parameter int POST_ZEROS = 40
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      half_tick,
    input  logic      buf_vld,
    input  logic      buf_last,
    output logic      first_en,
    output logic      second_en,
    output cell_src_e src,
    output logic      take,
    output logic      launch,
    output logic      accept_en,
    output logic      done
);

    localparam int MAXC = (PRE_ZEROS > POST_ZEROS) ? PRE_ZEROS : POST_ZEROS;
    localparam int CW   = $clog2(MAXC + 1);

    typedef struct packed {
        wr_state_e        st;
        logic [CW-1:0]    cnt;
        logic             half;
        logic             last;
        logic             done;
    } fr_t;

    fr_t fr_q, fr_d;

    always_comb begin
        fr_d      = fr_q;
        fr_d.done = 1'b0;
        first_en  = 1'b0;
        second_en = 1'b0;
        src       = SRC_ZERO;
        take      = 1'b0;
        launch    = 1'b0;
        accept_en = (fr_q.st == ST_DATA);
        unique case (fr_q.st)
            ST_IDLE: begin
                if (start) begin
                    launch    = 1'b1;
                    fr_d.st   = ST_PRE;
                    fr_d.cnt  = '0;
                    fr_d.half = 1'b0;
                    fr_d.last = 1'b0;
                end
            end
            ST_PRE: begin
                if (half_tick) begin
                    if (!fr_q.half) begin
                        first_en  = 1'b1;
                        src       = (fr_q.cnt == CW'(PRE_ZEROS)) ? SRC_ONES : SRC_ZERO;
                        fr_d.half = 1'b1;
                    end else begin
                        second_en = 1'b1;
                        fr_d.half = 1'b0;
                        if (fr_q.cnt == CW'(PRE_ZEROS)) begin
                            fr_d.st  = ST_DATA;
                            fr_d.cnt = '0;
                        end else begin
                            fr_d.cnt = fr_q.cnt + 1'b1;
                        end
                    end
                end
            end
            ST_DATA: begin
                if (half_tick) begin
                    if (!fr_q.half) begin
                        if (buf_vld) begin
                            first_en  = 1'b1;
                            src       = SRC_DATA;
                            take      = 1'b1;
                            fr_d.half = 1'b1;
                            fr_d.last = buf_last;
                        end
                    end else begin
                        second_en = 1'b1;
                        fr_d.half = 1'b0;
                        if (fr_q.last) begin
                            fr_d.st  = ST_POST;
                            fr_d.cnt = '0;
                        end
                    end
                end
            end
            ST_POST: begin
                if (half_tick) begin
                    if (!fr_q.half) begin
                        first_en  = 1'b1;
                        src       = (fr_q.cnt == '0) ? SRC_ONES : SRC_ZERO;
                        fr_d.half = 1'b1;
                    end else begin
                        second_en = 1'b1;
                        fr_d.half = 1'b0;
                        if (fr_q.cnt == CW'(POST_ZEROS)) begin
                            fr_d.st   = ST_IDLE;
                            fr_d.cnt  = '0;
                            fr_d.done = 1'b1;
                        end else begin
                            fr_d.cnt = fr_q.cnt + 1'b1;
                        end
                    end
                end
            end
            default: fr_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fr_q <= '0;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign done = fr_q.done;

    AST_TAKE_HAS_CHAR: assert property (@(posedge clk) disable iff (rst)
        take |-> buf_vld); // R8
    AST_DONE_ENDS_POST: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(fr_q.st) == ST_POST)); // R5
    AST_PRE_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        (fr_q.st == ST_PRE) |-> (fr_q.cnt <= CW'(PRE_ZEROS))); // R1

endmodule

// File: rtl/pe_wr_track.sv
module pe_wr_track (
    input  logic clk,
    input  logic rst,
    input  logic first_en,
    input  logic second_en,
    input  logic bit_in,
    output logic lvl
);

    typedef struct packed {
        logic lvl;
        logic bitv;
    } tk_t;

    tk_t tk_q, tk_d;

    always_comb begin
        tk_d = tk_q;
        if (first_en) begin
            tk_d.lvl  = !bit_in;
            tk_d.bitv = bit_in;
        end else if (second_en) begin
            tk_d.lvl = tk_q.bitv;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tk_q <= '0;
        end else begin
            tk_q <= tk_d;
        end
    end

    assign lvl = tk_q.lvl;

    AST_MID_CELL_EDGE: assert property (@(posedge clk) disable iff (rst)
        second_en |=> (lvl != $past(lvl))); // R2

endmodule

// File: rtl/pe_record_writer.sv
module pe_record_writer
    import pe_wr_pkg::*;
#(
    parameter int TRACKS     = 9,
    parameter int PRE_ZEROS  = 40,
    parameter int POST_ZEROS = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              half_tick,
    input  logic              start,
    input  logic              s_valid,
    input  logic [TRACKS-1:0] s_data,
    input  logic              s_last,
    output logic              s_ready,
    output logic [TRACKS-1:0] trk_out,
    output logic              done
);

    logic              first_en, second_en, take, launch, accept_en;
    logic              buf_vld, buf_last;
    logic [TRACKS-1:0] buf_data;
    logic [TRACKS-1:0] cell_char;
    cell_src_e         src;

    pe_wr_inbuf #(.WIDTH(TRACKS)) u_inbuf (
        .clk       (clk),
        .rst       (rst),
        .accept_en (accept_en),
        .clear     (launch),
        .take      (take),
        .s_valid   (s_valid),
        .s_data    (s_data),
        .s_last    (s_last),
        .s_ready   (s_ready),
        .buf_vld   (buf_vld),
        .buf_data  (buf_data),
        .buf_last  (buf_last)
    );

    pe_wr_framer #(.PRE_ZEROS(PRE_ZEROS), .POST_ZEROS(POST_ZEROS)) u_framer (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .half_tick (half_tick),
        .buf_vld   (buf_vld),
        .buf_last  (buf_last),
        .first_en  (first_en),
        .second_en (second_en),
        .src       (src),
        .take      (take),
        .launch    (launch),
        .accept_en (accept_en),
        .done      (done)
    );

    always_comb begin
        unique case (src)
            SRC_ONES: cell_char = '1;
            SRC_DATA: cell_char = buf_data;
            default:  cell_char = '0;
        endcase
    end

    for (genvar t = 0; t < TRACKS; t++) begin : g_track
        pe_wr_track u_track (
            .clk       (clk),
            .rst       (rst),
            .first_en  (first_en),
            .second_en (second_en),
            .bit_in    (cell_char[t]),
            .lvl       (trk_out[t])
        );
    end

    AST_LEVELS_WAIT_TICK: assert property (@(posedge clk) disable iff (rst)
        !half_tick |=> $stable(trk_out)); // R2

endmodule

// File: tb/pe_record_writer_test.sv
`timescale 1ns/1ps
module pe_record_writer_test;

    localparam int TR = 9;
    localparam int NZ = 40;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          half_tick = 1'b0;
    logic          start = 1'b0;
    logic          s_valid = 1'b0;
    logic [TR-1:0] s_data = '0;
    logic          s_last = 1'b0;
    logic          s_ready;
    logic [TR-1:0] trk_out;
    logic          done;

    always #2.5 clk = ~clk;

    pe_record_writer uut (
        .clk(clk), .rst(rst), .half_tick(half_tick), .start(start),
        .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
        .s_ready(s_ready), .trk_out(trk_out), .done(done)
    );

    int checks = 0;
    int errors = 0;

    logic [TR-1:0] exp_q[$];
    int            kind_q[$];
    bit            mon_en = 1'b0;
    bit            tick_run = 1'b0;
    int            half_ix = 0;
    int            bbuf = 0;
    int            cells_done = 0;
    bit            last_hs = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [TR-1:0] act, input logic [TR-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [TR-1:0] pat(input int mode, input int i);
        case (mode)
            0:       pat = 9'h0AA;
            1:       pat = TR'((i * 37 + 5) % 512);
            default: pat = (i % 2 == 0) ? 9'h000 : 9'h1FF;
        endcase
    endfunction

    // half-cell strobe generator, one pulse every four cycles
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            half_tick = tick_run && (cnt % 4 == 0);
            cnt++;
        end
    end

    // monitor: pops expected cells and compares levels after each strobe edge
    initial begin
        bit            pend = 1'b0;
        bit            exp_done = 1'b0;
        logic [TR-1:0] exp_lvl = '0;
        string         tag = "";
        forever begin
            @(negedge clk);
            #1;
            if (mon_en) begin
                if (pend) begin
                    chk(trk_out === exp_lvl, tag, trk_out, exp_lvl);
                    if (exp_done) chk(done === 1'b1, "R5 done pulse", TR'(done), TR'(1));
                end
                if (done && !(pend && exp_done)) chk(1'b0, "R5 stray done", TR'(done), TR'(0));
                if (exp_q.size() > 0 && (cells_done < NZ + 1 || last_hs)) begin
                    chk(s_ready === 1'b0, cells_done < NZ + 1 ? "R6 ready in framing" : "R7 ready after last",
                        TR'(s_ready), TR'(0));
                end
                pend = 1'b0;
                exp_done = 1'b0;
                if (half_tick && exp_q.size() > 0) begin
                    pend = 1'b1;
                    if (half_ix == 0) begin
                        if (kind_q[0] == 1 && bbuf == 0) begin
                            exp_lvl = trk_out;
                            tag = "R8 skipped strobe holds";
                        end else begin
                            exp_lvl = ~exp_q[0];
                            tag = (kind_q[0] == 0) ? "R1 R2 opening first half" :
                                  (kind_q[0] == 1) ? "R2 R3 R4 data first half" : "R5 closing first half";
                            half_ix = 1;
                            if (kind_q[0] == 1) bbuf--;
                        end
                    end else begin
                        exp_lvl = exp_q[0];
                        tag = (kind_q[0] == 0) ? "R1 R2 opening second half" :
                              (kind_q[0] == 1) ? "R2 R3 R4 data second half" : "R5 closing second half";
                        half_ix = 0;
                        void'(exp_q.pop_front());
                        void'(kind_q.pop_front());
                        cells_done++;
                        exp_done = (exp_q.size() == 0);
                    end
                end
                if (s_valid && s_ready) begin
                    bbuf++;
                    if (s_last) last_hs = 1'b1;
                end
            end
        end
    end

    task automatic open_record(input int n, input int mode);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        half_ix = 0; bbuf = 0; cells_done = 0; last_hs = 1'b0;
        for (int k = 0; k < NZ; k++) begin exp_q.push_back('0); kind_q.push_back(0); end
        exp_q.push_back('1); kind_q.push_back(0);
        for (int k = 0; k < n; k++) begin exp_q.push_back(pat(mode, k)); kind_q.push_back(1); end
        exp_q.push_back('1); kind_q.push_back(2);
        for (int k = 0; k < NZ; k++) begin exp_q.push_back('0); kind_q.push_back(2); end
    endtask

    task automatic run_record(input int n, input int mode, input int gap_at, input int gap, input bit restart);
        open_record(n, mode);
        for (int i = 0; i < n; i++) begin
            if (i == gap_at) begin
                @(negedge clk);
                s_valid = 1'b0;
                repeat (gap) @(negedge clk);
            end
            if (restart && i == 2) begin
                @(negedge clk);
                start = 1'b1;   // R9: must be ignored mid-record
                @(negedge clk);
                start = 1'b0;
            end
            @(negedge clk);
            s_valid = 1'b1;
            s_data  = pat(mode, i);
            s_last  = (i == n - 1);
            while (!s_ready) @(negedge clk);
        end
        @(negedge clk);
        s_valid = 1'b1;          // R7: offered after last, must not be written
        s_data  = 9'h155;
        s_last  = 1'b0;
        while (exp_q.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(s_ready === 1'b0, "R6 ready low in idle with valid high", TR'(s_ready), TR'(0));
        s_valid = 1'b0;
        chk(trk_out === '0, "R5 idle level after closing framing", trk_out, '0);
    endtask

    initial begin
        fork
            begin
                repeat (4) @(negedge clk);
                chk(trk_out === '0, "R10 reset levels", trk_out, '0);
                chk(s_ready === 1'b0, "R10 reset ready", TR'(s_ready), TR'(0));
                chk(done === 1'b0, "R10 reset done", TR'(done), TR'(0));
                rst = 1'b0;
                tick_run = 1'b1;
                repeat (20) @(negedge clk);
                chk(trk_out === '0, "R9 strobes while idle", trk_out, '0);
                mon_en = 1'b1;
                run_record(6, 0, -1, 0, 1'b0);   // equal characters: boundary reversals
                run_record(10, 1, 4, 30, 1'b1);  // mixed data, starved cell, stray start
                run_record(8, 2, 3, 12, 1'b0);   // alternating characters: no boundary edges
                run_record(1, 1, -1, 0, 1'b0);   // single character record
                // mid-record reset
                mon_en = 1'b0;
                open_record(3, 1);
                while (trk_out !== '1) @(negedge clk);
                rst = 1'b1;
                @(negedge clk);
                rst = 1'b0;
                #1;
                chk(trk_out === '0, "R10 reset mid-record levels", trk_out, '0);
                chk(s_ready === 1'b0, "R10 reset mid-record ready", TR'(s_ready), TR'(0));
                repeat (30) @(negedge clk);
                chk(trk_out === '0, "R10 idle after reset", trk_out, '0);
                exp_q.delete();
                kind_q.delete();
                mon_en = 1'b1;
                run_record(4, 2, -1, 0, 1'b0);
            end
            begin
                repeat (150000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: R5 record completion not reached");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule